// File: doc/BRIEF.md
# Parallel Configuration Load Sequencer

This block is the master side of a byte-wide configuration load for a programmable logic device. After a start command it pulls the device's active-low program request down for a minimum time, then releases it. It waits for the device to report that its configuration memory has been cleared. The clear time grows with the number of configuration frames, so the wait limit is computed from a frame count that is captured at start. The block then streams the bitstream, one byte for each rising edge of a configuration clock that it generates itself. After the last byte it gives a fixed number of additional clock pulses and watches for the device's done line.

Bytes come from an upstream source through a valid/ready handshake. The total byte count is captured at start. When the source has no byte ready, the configuration clock pauses in its low phase. No edge is ever issued with stale data. A byte changes only while the configuration clock is low, so it is settled before the rising edge and held through the high phase. If either wait runs past its limit, the block ends the sequence and reports an error. Otherwise it reports success. The result is held until the next start.

Top module: `cfg_seq`

## Requirements
- R1: After reset, prog_n is 1, cfg_clk is 0, and busy, ok and err are all 0.
- R2: A start pulse while idle raises busy and drives prog_n low for at least PROG_LOW system cycles, in a single low pulse. A start pulse while busy is ignored and gives no second program pulse.
- R3: After prog_n returns high, no cfg_clk edge is issued until init_rdy is 1. If init_rdy stays 0 for frame_cnt*CLR_PER_FRAME+INIT_MARGIN cycles, the sequence ends with err=1 and ok=0.
- R4: Each byte accepted from the source (src_valid and src_ready both 1) appears on cfg_data at exactly one cfg_clk rising edge, in acceptance order. cfg_data changes only while cfg_clk is low.
- R5: Each high phase of cfg_clk lasts exactly CCLK_HALF system cycles.
- R6: While the source holds src_valid at 0, cfg_clk gives no rising edge beyond the one for the byte already taken.
- R7: After the last of byte_total bytes, exactly EXTRA_CYC more cfg_clk rising edges are issued. With byte_total=0, only those EXTRA_CYC edges are issued.
- R8: If done is 1 within DONE_WAIT cycles after the extra edges, the sequence ends with ok=1. Otherwise it ends with err=1. ok and err are never both 1, and busy falls when either is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration load (sampled while idle) |
| frame_cnt | input | FW | Number of configuration frames, used for the clear wait limit |
| byte_total | input | BW | Number of bitstream bytes to send |
| src_data | input | 8 | Byte offered by the source |
| src_valid | input | 1 | Source byte is valid |
| src_ready | output | 1 | Sequencer takes the byte this cycle if valid |
| prog_n | output | 1 | Active-low program request to the device |
| init_rdy | input | 1 | Device reports its configuration memory is cleared |
| cfg_clk | output | 1 | Configuration clock to the device |
| cfg_data | output | 8 | Configuration data byte to the device |
| done | input | 1 | Device reports configuration complete |
| busy | output | 1 | A sequence is in progress |
| ok | output | 1 | Last sequence finished successfully |
| err | output | 1 | Last sequence timed out |

## Verification
The embedded assertions check several rules on every cycle. The data byte moves only while the configuration clock is low. The clock stays low outside the streaming and trailing phases. Every toggle ends a full half period. The clock runs in streaming only when a byte is held. The program request coincides with busy, and the success and error flags are exclusive. The directed scenarios are needed for properties that span a whole sequence. These are the byte order and count seen by the device, the number of trailing pulses, and the minimum program pulse width. They also cover the pause of the clock during a source stall, and the two timeout outcomes for a missing clear and a missing done.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PROG   = 3'd1,
    S_WINIT  = 3'd2,
    S_STREAM = 3'd3,
    S_EXTRA  = 3'd4,
    S_WDONE  = 3'd5
  } seq_st_e;
endpackage

// File: rtl/cfg_tmr.sv
module cfg_tmr #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                cnt_d = val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cfg_cclk.sv
module cfg_cclk #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic clk_o,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          wrap;

  assign wrap = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!run)      cnt_d = '0;
    else if (wrap) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign clk_o = lvl_q;
  assign rise  = wrap && !lvl_q;
  assign fall  = wrap &&  lvl_q;

  // R5: a level change only ever follows a completed half period
  p_half_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == LAST && $past(run)));
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_pkg::*;
#(
  parameter int PROG_LOW      = 8,
  parameter int CCLK_HALF     = 2,
  parameter int CLR_PER_FRAME = 25,
  parameter int INIT_MARGIN   = 64,
  parameter int EXTRA_CYC     = 8,
  parameter int DONE_WAIT     = 256,
  parameter int FW            = 16,
  parameter int BW            = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] frame_cnt,
  input  logic [BW-1:0] byte_total,
  input  logic [7:0]    src_data,
  input  logic          src_valid,
  output logic          src_ready,
  output logic          prog_n,
  input  logic          init_rdy,
  output logic          cfg_clk,
  output logic [7:0]    cfg_data,
  input  logic          done,
  output logic          busy,
  output logic          ok,
  output logic          err
);
  localparam int TW = 32;
  localparam int EW = $clog2(EXTRA_CYC + 1);
  localparam logic [EW-1:0] EXTRA_V = EW'(EXTRA_CYC);

  seq_st_e       st_q, st_d;
  logic [BW-1:0] left_q, left_d;
  logic [FW-1:0] frm_q, frm_d;
  logic [EW-1:0] ext_q, ext_d;
  logic [7:0]    dat_q, dat_d;
  logic          have_q, have_d;
  logic          ok_q, ok_d, err_q, err_d;

  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val, init_lim;
  logic          run, rise, fall, take;

  assign init_lim = TW'(frm_q) * TW'(CLR_PER_FRAME) + TW'(INIT_MARGIN);

  cfg_tmr #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .val(tmr_val), .zero(tmr_zero)
  );

  cfg_cclk #(.HALF(CCLK_HALF)) u_cclk (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_o(cfg_clk), .rise(rise), .fall(fall)
  );

  assign src_ready = (st_q == S_STREAM) && !have_q && !cfg_clk;
  assign take      = src_ready && src_valid;
  assign run       = ((st_q == S_STREAM) && have_q) || (st_q == S_EXTRA);

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    frm_d   = frm_q;
    ext_d   = ext_q;
    dat_d   = dat_q;
    have_d  = have_q;
    ok_d    = ok_q;
    err_d   = err_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d    = S_PROG;
        ok_d    = 1'b0;
        err_d   = 1'b0;
        left_d  = byte_total;
        frm_d   = frame_cnt;
        tmr_ld  = 1'b1;
        tmr_val = TW'(PROG_LOW);
      end
      S_PROG: if (tmr_zero) begin
        st_d    = S_WINIT;
        tmr_ld  = 1'b1;
        tmr_val = init_lim;
      end
      S_WINIT: begin
        if (init_rdy) begin
          if (left_q == '0) begin
            st_d  = S_EXTRA;
            ext_d = EXTRA_V;
          end else st_d = S_STREAM;
        end else if (tmr_zero) begin
          st_d  = S_IDLE;
          err_d = 1'b1;
        end
      end
      S_STREAM: begin
        if (take) begin
          have_d = 1'b1;
          dat_d  = src_data;
        end
        if (fall) begin
          have_d = 1'b0;
          left_d = left_q - 1'b1;
          if (left_q == BW'(1)) begin
            st_d  = S_EXTRA;
            ext_d = EXTRA_V;
          end
        end
      end
      S_EXTRA: if (fall) begin
        ext_d = ext_q - 1'b1;
        if (ext_q == EW'(1)) begin
          st_d    = S_WDONE;
          tmr_ld  = 1'b1;
          tmr_val = TW'(DONE_WAIT);
        end
      end
      S_WDONE: begin
        if (done) begin
          st_d = S_IDLE;
          ok_d = 1'b1;
        end else if (tmr_zero) begin
          st_d  = S_IDLE;
          err_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      left_q <= '0;
      frm_q  <= '0;
      ext_q  <= '0;
      dat_q  <= '0;
      have_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      frm_q  <= frm_d;
      ext_q  <= ext_d;
      dat_q  <= dat_d;
      have_q <= have_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
    end
  end

  assign cfg_data = dat_q;
  assign prog_n   = (st_q != S_PROG);
  assign busy     = (st_q != S_IDLE);
  assign ok       = ok_q;
  assign err      = err_q;

  // R4: the data byte moves only while the configuration clock is low
  p_data_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data != $past(cfg_data)) |-> (!cfg_clk && !$past(cfg_clk)));
  // R3: no clock activity before the device has cleared or after the trailer
  p_clk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {S_IDLE, S_PROG, S_WINIT, S_WDONE}) |-> !cfg_clk);
  // R6: a rising edge in streaming always carries a held byte
  p_no_empty_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STREAM && rise) |-> have_q);
  // R2: program request is only low inside a busy sequence
  p_prog_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> busy);
  // R8: success and error never coexist
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err));
endmodule

// File: tb/sim_cfg_seq.sv
module sim_cfg_seq;
  localparam int PROG_LOW = 5, HALF = 2, CPF = 10, MARG = 8, EXTRA = 4, DWAIT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] frame_cnt = 16'd3;
  logic [23:0] byte_total = '0;
  logic [7:0]  src_data;
  logic src_valid, src_ready, prog_n, init_rdy, cfg_clk, done, busy, ok, err;
  logic [7:0] cfg_data;

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int idx = 0, cur_total = 0, init_dly = 10, icnt = 0;
  int rises = 0, plow = 0, pulses = 0, hi_cyc = 0, exp_rises = 0;
  logic hold = 1'b0, done_en = 1'b1, init_q = 1'b0;
  logic [7:0] seed = 8'h00;
  logic [7:0] cap [0:255];

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 37 + 5) ^ s;
  endfunction

  assign src_data  = pat(idx, seed);
  assign src_valid = !hold && (idx < cur_total);
  assign init_rdy  = init_q;
  assign done      = done_en && (rises >= exp_rises) && (exp_rises > 0);

  cfg_seq #(.PROG_LOW(PROG_LOW), .CCLK_HALF(HALF), .CLR_PER_FRAME(CPF),
            .INIT_MARGIN(MARG), .EXTRA_CYC(EXTRA), .DONE_WAIT(DWAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_cnt(frame_cnt),
    .byte_total(byte_total), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .prog_n(prog_n), .init_rdy(init_rdy),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .done(done), .busy(busy),
    .ok(ok), .err(err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_valid && src_ready) idx <= idx + 1;
    if (!prog_n) begin init_q <= 1'b0; icnt <= 0; plow <= plow + 1; end
    else if (!init_q) begin
      if (icnt >= init_dly) init_q <= 1'b1;
      else icnt <= icnt + 1;
    end
    if (cfg_clk) hi_cyc <= hi_cyc + 1;
  end
  always @(posedge cfg_clk) begin
    if (rises < 256) cap[rises] <= cfg_data;
    rises <= rises + 1;
  end
  always @(negedge prog_n) pulses <= pulses + 1;

  task automatic check(input bit c, input string req, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input int n, input int dly, input bit den, input logic [7:0] s);
    @(negedge clk);
    idx = 0; cur_total = n; init_dly = dly; done_en = den; seed = s;
    rises = 0; plow = 0; pulses = 0; hi_cyc = 0; exp_rises = n + EXTRA;
    byte_total = 24'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
    check(!busy, "R8 sequence ends", busy, 0);
  endtask

  task automatic check_bytes(input int n, input string req);
    int mism = 0;
    for (int i = 0; i < n; i++) if (cap[i] !== pat(i, seed)) mism++;
    check(mism == 0, req, mism, 0);
  endtask

  task automatic t_reset();
    check(prog_n === 1'b1 && cfg_clk === 1'b0, "R1 lines idle", {prog_n, cfg_clk}, 2);
    check(!busy && !ok && !err, "R1 flags clear", {busy, ok, err}, 0);
  endtask

  task automatic t_normal();
    prep(20, 10, 1'b1, 8'h3c);
    check(busy === 1'b1, "R2 busy after start", busy, 1);
    wait_idle();
    check(ok && !err, "R8 ok set", {ok, err}, 2);
    check(plow >= PROG_LOW, "R2 prog low width", plow, PROG_LOW);
    check(pulses == 1, "R2 one pulse", pulses, 1);
    check(rises == 20 + EXTRA, "R7 edge count", rises, 20 + EXTRA);
    check_bytes(20, "R4 byte order");
    check(hi_cyc == rises * HALF, "R5 high phase", hi_cyc, rises * HALF);
  endtask

  task automatic t_stall();
    int r0;
    prep(12, 6, 1'b1, 8'ha5);
    for (int k = 0; k < 2000 && rises < 4; k++) @(negedge clk);
    hold = 1'b1;
    repeat (8) @(negedge clk);
    r0 = rises;
    repeat (30) @(negedge clk);
    check(rises == r0, "R6 clock paused in stall", rises, r0);
    hold = 1'b0;
    wait_idle();
    check_bytes(12, "R6 data intact after stall");
    check(ok && rises == 12 + EXTRA, "R6 stall run completes", rises, 12 + EXTRA);
  endtask

  task automatic t_zero();
    prep(0, 4, 1'b1, 8'h00);
    wait_idle();
    check(rises == EXTRA, "R7 zero bytes trailer only", rises, EXTRA);
    check(ok && !err, "R7 zero bytes ok", {ok, err}, 2);
  endtask

  task automatic t_init_to();
    prep(8, 1000, 1'b1, 8'h11);
    wait_idle();
    check(err && !ok, "R3 clear timeout error", {ok, err}, 1);
    check(rises == 0, "R3 no clock before clear", rises, 0);
  endtask

  task automatic t_done_to();
    prep(6, 5, 1'b0, 8'h77);
    wait_idle();
    check(err && !ok, "R8 done timeout error", {ok, err}, 1);
    check(rises == 6 + EXTRA, "R7 trailer before done wait", rises, 6 + EXTRA);
  endtask

  task automatic t_restart_ignored();
    prep(10, 10, 1'b1, 8'h5a);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(pulses == 1, "R2 start while busy ignored", pulses, 1);
    check(ok && rises == 10 + EXTRA, "R2 run unaffected", rises, 10 + EXTRA);
    check_bytes(10, "R4 bytes after ignored start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_stall();
    t_zero();
    t_init_to();
    t_done_to();
    t_restart_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule